// File: doc/BRIEF.md
# Two-Tier Interrupt Pending and Mask Controller

This block gathers interrupt requests from a set of main sources, some of which are fed by groups of sub-sources, and presents a single IRQ line and a single FIQ line to a processor core. A sub-source request is latched into a sub-pending register. If its sub-mask bit is clear, the request then sets the source-pending bit of the main source that the whole group shares. Source-pending bits pass a main mask. A per-source mode bit then sends each one either to the FIQ output or into a fixed-priority selector for IRQ.

The selector's winner is latched as a single bit in a final pending register, and its index is published in an offset register. The final register only loads while it is empty, so one IRQ source is presented until software retires it. All pending flags are write-one-to-clear. Software clears them from the bottom tier upward: sub-pending, then source-pending, then final. A simple register bus with a combinational read port gives access to every register. Register addresses: 0 sub-pending, 1 sub-mask, 2 source-pending, 3 main mask, 4 mode, 5 final pending, 6 offset (read only).

Top module: `irqc_ctrl`

## Requirements
- R1: After reset, every sub-mask and main-mask bit reads 1, the mode register reads 0 (all IRQ), all pending registers and the offset read 0, and `irq_o` and `fiq_o` are low.
- R2: A high `sub_req[i]` at a clock edge sets bit i of the sub-pending register (address 0) at that edge.
- R3: A sub-pending bit sets its parent's source-pending bit (address 2) one edge later only while its sub-mask bit (address 1) is 0. With the sub-mask bit at 1, the parent bit stays clear.
- R4: Sub-sources are grouped in fours. Sub-sources 0 to 3 share main source 28, and sub-sources 4 to 7 share main source 29. Several active sub-sources of one group set only that one shared bit.
- R5: A source-pending bit takes part in IRQ or FIQ signalling only while its main mask bit (address 3) is 0.
- R6: A mode bit (address 4) of 1 routes the source to FIQ. `fiq_o` is the OR of the unmasked source-pending bits in FIQ mode, and such sources never enter the final pending register.
- R7: Among unmasked source-pending bits in IRQ mode, the lowest index wins. Exactly one bit is set in the final pending register (address 5), and `irq_o` is high while that register is non-zero.
- R8: Writing 1 to a bit of a pending register clears it, and writing 0 leaves it unchanged. A request in the same cycle as the clear keeps the bit set.
- R9: Clearing a source-pending bit whose group still has an unmasked active sub-pending bit leaves the bit set.
- R10: The final pending register loads only while it is empty. Once loaded, it holds its bit against later higher-priority requests until software clears it.
- R11: The offset register (address 6) reads the index of the bit set in the final pending register, and reads 0 when that register is empty.
- R12: The sub-mask, main mask and mode registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Direct request lines of the main sources |
| sub_req | input | NUM_SUB | Request lines of the sub-sources |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | IRQ request to the core |
| fiq_o | output | 1 | FIQ request to the core |

## Verification
The assertions assume that a write strobe is the only way a pending flag can fall, and that bus writes arrive as single-cycle strobes with a defined address. The stimulus keeps to this by driving requests as one-cycle pulses and issuing every register access from tasks that raise the strobe for exactly one clock. The stimulus also clears flags in the bottom-up order the block expects. Each check lets the two-register path from sub-request to final pending settle before it samples.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DW = 32;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        RA_SUBPEND = 3'd0,
        RA_SUBMASK = 3'd1,
        RA_SRCPEND = 3'd2,
        RA_MASK    = 3'd3,
        RA_MODE    = 3'd4,
        RA_FINPEND = 3'd5,
        RA_OFFSET  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_req_t;

    function automatic logic is_write_to(bus_req_t r, reg_addr_e a);
        return r.wr && (r.addr == a);
    endfunction

endpackage

// File: rtl/irqc_sub_stage.sv
module irqc_sub_stage
    import irqc_pkg::*;
#(
    parameter int NUM_SUB  = 8,
    parameter int GRP_SIZE = 4,
    localparam int NUM_GRP = NUM_SUB / GRP_SIZE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SUB-1:0] sub_req,
    input  logic [NUM_SUB-1:0] sub_clr,
    input  logic [NUM_SUB-1:0] sub_mask,
    output logic [NUM_SUB-1:0] sub_pnd,
    output logic [NUM_GRP-1:0] grp_hit
);

    always_ff @(posedge clk) begin
        if (rst) sub_pnd <= '0;
        else     sub_pnd <= (sub_pnd & ~sub_clr) | sub_req;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp_hit[g] = |(sub_pnd[g*GRP_SIZE +: GRP_SIZE]
                            & ~sub_mask[g*GRP_SIZE +: GRP_SIZE]);
    end

endmodule

// File: rtl/irqc_src_stage.sv
module irqc_src_stage
    import irqc_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_GRP  = 2,
    parameter int GRP_BASE = 28
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_GRP-1:0] grp_hit,
    input  logic [NUM_SRC-1:0] src_clr,
    input  logic [NUM_SRC-1:0] src_mask,
    input  logic [NUM_SRC-1:0] src_mode,
    output logic [NUM_SRC-1:0] src_pnd,
    output logic [NUM_SRC-1:0] irq_cand,
    output logic               fiq_any
);

    logic [NUM_SRC-1:0] grp_set;
    logic [NUM_SRC-1:0] live;

    always_comb begin
        grp_set = '0;
        for (int g = 0; g < NUM_GRP; g++) grp_set[GRP_BASE+g] = grp_hit[g];
    end

    always_ff @(posedge clk) begin
        if (rst) src_pnd <= '0;
        else     src_pnd <= (src_pnd & ~src_clr) | src_req | grp_set;
    end

    assign live     = src_pnd & ~src_mask;
    assign irq_cand = live & ~src_mode;
    assign fiq_any  = |(live & src_mode);

endmodule

// File: rtl/irqc_prio_sel.sv
module irqc_prio_sel
    import irqc_pkg::*;
#(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        onehot = '0;
        idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                idx       = IW'(i);
            end
        end
    end

    assign any = |cand;

endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SUB  = 8,
    parameter int GRP_SIZE = 4,
    parameter int GRP_BASE = 28
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SUB-1:0] sub_req,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);

    localparam int NUM_GRP = NUM_SUB / GRP_SIZE;
    localparam int IW      = $clog2(NUM_SRC);

    bus_req_t           breq;
    logic [NUM_SUB-1:0] submask_r, sub_clr, sub_pnd;
    logic [NUM_GRP-1:0] grp_hit;
    logic [NUM_SRC-1:0] mask_r, mode_r, src_clr, src_pnd, irq_cand;
    logic [NUM_SRC-1:0] fin_pnd, fin_nxt, fin_clr, win_onehot;
    logic [IW-1:0]      offset, off_nxt, win_idx;
    logic               win_any, fiq_any;

    assign breq.wr   = bus_en && bus_we;
    assign breq.addr = bus_addr;
    assign breq.data = bus_wdata;

    assign sub_clr = is_write_to(breq, RA_SUBPEND) ? breq.data[NUM_SUB-1:0] : '0;
    assign src_clr = is_write_to(breq, RA_SRCPEND) ? breq.data[NUM_SRC-1:0] : '0;
    assign fin_clr = is_write_to(breq, RA_FINPEND) ? breq.data[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            submask_r <= '1;
            mask_r    <= '1;
            mode_r    <= '0;
        end else begin
            if (is_write_to(breq, RA_SUBMASK)) submask_r <= breq.data[NUM_SUB-1:0];
            if (is_write_to(breq, RA_MASK))    mask_r    <= breq.data[NUM_SRC-1:0];
            if (is_write_to(breq, RA_MODE))    mode_r    <= breq.data[NUM_SRC-1:0];
        end
    end

    irqc_sub_stage #(.NUM_SUB(NUM_SUB), .GRP_SIZE(GRP_SIZE)) i_sub (
        .clk(clk), .rst(rst), .sub_req(sub_req), .sub_clr(sub_clr),
        .sub_mask(submask_r), .sub_pnd(sub_pnd), .grp_hit(grp_hit)
    );

    irqc_src_stage #(.NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .GRP_BASE(GRP_BASE)) i_src (
        .clk(clk), .rst(rst), .src_req(src_req), .grp_hit(grp_hit),
        .src_clr(src_clr), .src_mask(mask_r), .src_mode(mode_r),
        .src_pnd(src_pnd), .irq_cand(irq_cand), .fiq_any(fiq_any)
    );

    irqc_prio_sel #(.N(NUM_SRC)) i_prio (
        .cand(irq_cand), .onehot(win_onehot), .idx(win_idx), .any(win_any)
    );

    always_comb begin
        fin_nxt = fin_pnd;
        off_nxt = offset;
        if (fin_pnd == '0) begin
            if (win_any) begin
                fin_nxt = win_onehot;
                off_nxt = win_idx;
            end
        end else begin
            fin_nxt = fin_pnd & ~fin_clr;
            if (fin_nxt == '0) off_nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fin_pnd <= '0;
            offset  <= '0;
        end else begin
            fin_pnd <= fin_nxt;
            offset  <= off_nxt;
        end
    end

    always_comb begin
        unique case (bus_addr)
            RA_SUBPEND: bus_rdata = DW'(sub_pnd);
            RA_SUBMASK: bus_rdata = DW'(submask_r);
            RA_SRCPEND: bus_rdata = DW'(src_pnd);
            RA_MASK:    bus_rdata = DW'(mask_r);
            RA_MODE:    bus_rdata = DW'(mode_r);
            RA_FINPEND: bus_rdata = DW'(fin_pnd);
            RA_OFFSET:  bus_rdata = DW'(offset);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_o = |fin_pnd;
    assign fiq_o = fiq_any;

endmodule

// File: rtl/irqc_ctrl_chk.sv
module irqc_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_SUB = 8,
    localparam int IW = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_en,
    input logic               bus_we,
    input logic [AW-1:0]      bus_addr,
    input logic [DW-1:0]      bus_wdata,
    input logic [NUM_SUB-1:0] sub_req,
    input logic [NUM_SUB-1:0] sub_pnd,
    input logic [NUM_SRC-1:0] fin_pnd,
    input logic [IW-1:0]      offset,
    input logic [NUM_SRC-1:0] mask_r,
    input logic [NUM_SRC-1:0] mode_r
);

    logic [NUM_SUB-1:0] sub_w1;
    logic               fin_w;

    assign sub_w1 = (bus_en && bus_we && bus_addr == 3'd0) ? bus_wdata[NUM_SUB-1:0] : '0;
    assign fin_w  = bus_en && bus_we && bus_addr == 3'd5;

    a_r2_sub_latch: assert property (@(posedge clk) disable iff (rst)
        (sub_req != '0) |=> ((sub_pnd & $past(sub_req)) == $past(sub_req)));

    a_r8_sub_fall_only_w1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~sub_pnd & $past(sub_pnd) & ~$past(sub_w1)) == '0));

    a_r7_final_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fin_pnd));

    a_r5_load_unmasked_irq: assert property (@(posedge clk) disable iff (rst)
        (fin_pnd == '0) |=> ((fin_pnd & $past(mask_r | mode_r)) == '0));

    a_r10_hold_final: assert property (@(posedge clk) disable iff (rst)
        (fin_pnd != '0 && !fin_w) |=> (fin_pnd == $past(fin_pnd)));

    a_r11_offset_matches: assert property (@(posedge clk) disable iff (rst)
        (fin_pnd != '0) |-> fin_pnd[offset]);

endmodule

bind irqc_ctrl irqc_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_SUB(NUM_SUB)) i_chk (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sub_req(sub_req), .sub_pnd(sub_pnd), .fin_pnd(fin_pnd),
    .offset(offset), .mask_r(mask_r), .mode_r(mode_r)
);

// File: tb/test_irqc_ctrl.sv
module test_irqc_ctrl;

    localparam int A_SUBPEND = 0, A_SUBMASK = 1, A_SRCPEND = 2, A_MASK = 3;
    localparam int A_MODE = 4, A_FINPEND = 5, A_OFFSET = 6;
    localparam int K_REG = 0, K_IRQ = 1, K_FIQ = 2;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_req = '0;
    logic [7:0]  sub_req = '0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    logic        probe = 1'b0;

    sb_item_t sb_q[$];
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irqc_ctrl i_irqc_ctrl (
        .clk(clk), .rst(rst), .src_req(src_req), .sub_req(sub_req),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // Monitor: pops the expected item and compares away from the active edge
    always @(negedge clk) begin
        if (probe && sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_IRQ:   act = {31'd0, irq_o};
                K_FIQ:   act = {31'd0, fiq_o};
                default: act = bus_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = 3'(a); bus_wdata = d;
        tick(1);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic expect_item(int kind, int a, logic [31:0] e, string tag);
        sb_item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_en = (kind == K_REG); bus_we = 0; bus_addr = 3'(a);
        probe = 1;
        tick(1);
        probe = 0; bus_en = 0;
    endtask

    task automatic rd(int a, logic [31:0] e, string tag);
        expect_item(K_REG, a, e, tag);
    endtask

    task automatic pulse_src(logic [31:0] m);
        src_req = m; tick(1); src_req = '0;
    endtask

    task automatic pulse_sub(logic [7:0] m);
        sub_req = m; tick(1); sub_req = '0;
    endtask

    initial begin
        tick(3);
        rst = 0;
        // R1 reset state
        rd(A_SUBMASK, 32'hFF, "R1 submask");
        rd(A_MASK, 32'hFFFF_FFFF, "R1 mask");
        rd(A_MODE, 32'h0, "R1 mode");
        rd(A_SRCPEND, 32'h0, "R1 srcpend");
        rd(A_SUBPEND, 32'h0, "R1 subpend");
        rd(A_OFFSET, 32'h0, "R1 offset");
        expect_item(K_IRQ, 0, 0, "R1 irq");
        expect_item(K_FIQ, 0, 0, "R1 fiq");

        // R5 masked source latches but is not forwarded
        pulse_src(32'h8);
        tick(3);
        rd(A_SRCPEND, 32'h8, "R5 srcpend latched");
        rd(A_FINPEND, 32'h0, "R5 masked not final");
        expect_item(K_IRQ, 0, 0, "R5 irq low");

        wr(A_MASK, ~32'h3000_040A);
        rd(A_MASK, ~32'h3000_040A, "R12 mask readback");
        tick(2);
        rd(A_FINPEND, 32'h8, "R7 final");
        rd(A_OFFSET, 32'd3, "R11 offset 3");
        expect_item(K_IRQ, 0, 1, "R7 irq high");

        // R10 higher priority arrives while final held
        pulse_src(32'h2);
        tick(2);
        rd(A_SRCPEND, 32'hA, "R10 srcpend both");
        rd(A_FINPEND, 32'h8, "R10 final held");

        // R8 zero writes do nothing
        wr(A_SRCPEND, 32'h0);
        wr(A_FINPEND, 32'h0);
        rd(A_SRCPEND, 32'hA, "R8 zero write srcpend");
        rd(A_FINPEND, 32'h8, "R8 zero write final");

        wr(A_SRCPEND, 32'h8);
        wr(A_FINPEND, 32'h8);
        tick(2);
        rd(A_FINPEND, 32'h2, "R7 next winner");
        rd(A_OFFSET, 32'd1, "R11 offset 1");
        wr(A_SRCPEND, 32'h2);
        wr(A_FINPEND, 32'h2);
        tick(2);
        rd(A_FINPEND, 32'h0, "R8 final cleared");
        rd(A_OFFSET, 32'd0, "R11 offset empty");
        expect_item(K_IRQ, 0, 0, "R7 irq low");

        // R2/R3 sub-source masked then unmasked
        pulse_sub(8'h04);
        tick(3);
        rd(A_SUBPEND, 32'h4, "R2 subpend");
        rd(A_SRCPEND, 32'h0, "R3 submasked blocked");
        wr(A_SUBMASK, 32'hFB);
        rd(A_SUBMASK, 32'hFB, "R12 submask readback");
        tick(3);
        rd(A_SRCPEND, 32'h1000_0000, "R3 parent set");
        rd(A_FINPEND, 32'h1000_0000, "R3 parent final");
        rd(A_OFFSET, 32'd28, "R11 offset 28");

        // R9 parent re-sets while sub still pending
        wr(A_SRCPEND, 32'h1000_0000);
        tick(1);
        rd(A_SRCPEND, 32'h1000_0000, "R9 parent re-set");

        wr(A_SUBPEND, 32'h4);
        wr(A_SRCPEND, 32'h1000_0000);
        wr(A_FINPEND, 32'h1000_0000);
        tick(2);
        rd(A_SUBPEND, 32'h0, "R8 subpend cleared");
        rd(A_SRCPEND, 32'h0, "R8 srcpend cleared");
        rd(A_FINPEND, 32'h0, "R8 final empty");

        // R4 group sharing
        wr(A_SUBMASK, 32'hD5);
        pulse_sub(8'h2A);
        tick(3);
        rd(A_SUBPEND, 32'h2A, "R4 subpend");
        rd(A_SRCPEND, 32'h3000_0000, "R4 shared parents");
        rd(A_FINPEND, 32'h1000_0000, "R4 lower group wins");

        // R6 FIQ routing
        wr(A_MODE, 32'h400);
        rd(A_MODE, 32'h400, "R12 mode readback");
        pulse_src(32'h400);
        tick(2);
        expect_item(K_FIQ, 0, 1, "R6 fiq high");
        rd(A_FINPEND, 32'h1000_0000, "R6 fiq not final");
        wr(A_MASK, 32'hFFFF_FFFF);
        tick(1);
        expect_item(K_FIQ, 0, 0, "R5 fiq masked");
        expect_item(K_IRQ, 0, 1, "R10 irq held");

        tick(2);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule